// File: doc/BRIEF.md
# Reload Down-Counter Baud Clock Generator

This block makes the bit clock for a serial port from the peripheral clock. A 12-bit reload value and a control word are written through a small write port. Setting the run bit copies the reload value into a down counter. The counter then steps down once per clock. When it reaches zero it raises a one-cycle underflow pulse and loads the reload value again. Each underflow therefore lasts `reload + 1` clocks. A toggle stage inverts the serial clock on every underflow, so the serial clock has a 50% duty cycle at half the underflow rate.

A second stage serves asynchronous links. It counts the rising edges of the serial clock and emits a one-cycle sample tick on every 16th or every 8th rising edge, as chosen by a bit in the control word. Clearing the run bit freezes the counter, holds the serial clock low and clears the tick prescaler. The block carries no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `baud_reload_gen`

## Requirements
- R1: After reset, `count_o` is 0 and `uflow_o`, `sclk_o` and `tick_o` are all low.
- R2: Writing the control word (`wr_sel`=1) with bit 0 = 1 while stopped loads the current reload value into `count_o` on that clock edge.
- R3: While running, a nonzero count decreases by exactly 1 on every clock.
- R4: While running, `uflow_o` is high in each cycle where the count is 0, and the next edge loads the reload value. The first underflow comes `reload` cycles after the start edge, and later underflows come every `reload + 1` cycles. A reload of 0 gives an underflow on every cycle.
- R5: While running, `sclk_o` inverts on exactly the edges that end an underflow cycle, and it is low when the block starts.
- R6: Writing the control word with bit 0 = 0 stops the block. The count then holds, and `uflow_o`, `sclk_o` and `tick_o` stay low.
- R7: A reload write (`wr_sel`=0) while running does not disturb the current countdown. The new value first appears in the count at the next underflow reload.
- R8: A control write with bit 0 = 1 while already running does not reload the counter. Counting simply continues.
- R9: `tick_o` pulses for one cycle in the underflow cycle that produces every Nth rising edge of `sclk_o` since start. N is 8 when control bit 1 = 1 and 16 when it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one clock |
| wr_sel | input | 1 | 0 selects the reload register, 1 selects the control word (bit 0 run, bit 1 divide-by-8) |
| wr_data | input | CNT_W | Write value |
| count_o | output | CNT_W | Present counter value |
| uflow_o | output | 1 | High in each cycle where the running counter sits at zero |
| sclk_o | output | 1 | Serial clock, toggled on each underflow |
| tick_o | output | 1 | Asynchronous-mode sample tick |

## Verification
All outputs are functions of registered state only. A write driven before edge n therefore shows its effect one edge later. The count shows the reload value one edge after the start write. The first underflow appears `reload` cycles after that edge. The serial clock flips one edge after each underflow cycle. The bench drives inputs on falling edges and compares every output against a behavioural model at each falling edge, which is half a cycle after the edge that updated the state. Directed checks count falling edges from a known write to the expected event. For example, a reload of 2 in divide-by-8 mode gives the first tick 44 cycles after the start write.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    SEL_RELOAD = 1'b0,
    SEL_CTRL   = 1'b1
  } wsel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_FAST_BIT = 1;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] reload_q,
  output logic             run_q,
  output logic             run_nxt,
  output logic             fast_q
);
  logic ctrl_wr;
  logic rel_wr;

  assign ctrl_wr = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);
  assign rel_wr  = wr_en && (wsel_e'(wr_sel) == SEL_RELOAD);
  assign run_nxt = ctrl_wr ? wr_data[CTRL_RUN_BIT] : run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      run_q    <= 1'b0;
      fast_q   <= 1'b0;
    end else begin
      if (rel_wr) reload_q <= wr_data;
      if (ctrl_wr) fast_q <= wr_data[CTRL_FAST_BIT];
      run_q <= run_nxt;
    end
  end
endmodule

// File: rtl/baud_downcnt.sv
module baud_downcnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_q,
  input  logic             run_nxt,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             uflow
);
  logic start;

  assign start = !run_q && run_nxt;
  assign uflow = run_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= reload;
    end else if (run_q && run_nxt) begin
      cnt_q <= uflow ? reload : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/baud_clkdiv.sv
module baud_clkdiv #(
  parameter int DIV_SLOW = 16,
  parameter int DIV_FAST = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_nxt,
  input  logic uflow,
  input  logic fast,
  output logic sclk_q,
  output logic tick
);
  localparam int PRE_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim_m1;
  logic             rise;
  logic             wrap;

  assign lim_m1 = fast ? PRE_W'(DIV_FAST - 1) : PRE_W'(DIV_SLOW - 1);
  assign rise   = uflow && !sclk_q;
  assign wrap   = pre_q >= lim_m1;
  assign tick   = rise && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      pre_q  <= '0;
    end else if (!run_nxt) begin
      sclk_q <= 1'b0;
      pre_q  <= '0;
    end else if (uflow) begin
      sclk_q <= ~sclk_q;
      if (rise) pre_q <= wrap ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/baud_reload_gen.sv
module baud_reload_gen #(
  parameter int CNT_W    = 12,
  parameter int DIV_SLOW = 16,
  parameter int DIV_FAST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_o,
  output logic             uflow_o,
  output logic             sclk_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] reload_q;
  logic             run_q;
  logic             run_nxt;
  logic             fast_q;

  baud_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .reload_q (reload_q),
    .run_q    (run_q),
    .run_nxt  (run_nxt),
    .fast_q   (fast_q)
  );

  baud_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_q   (run_q),
    .run_nxt (run_nxt),
    .reload  (reload_q),
    .cnt_q   (count_o),
    .uflow   (uflow_o)
  );

  baud_clkdiv #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_nxt (run_nxt),
    .uflow   (uflow_o),
    .fast    (fast_q),
    .sclk_q  (sclk_o),
    .tick    (tick_o)
  );
endmodule

// File: rtl/baud_reload_gen_chk.sv
module baud_reload_gen_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_o,
  input logic             uflow_o,
  input logic             sclk_o,
  input logic             tick_o
);
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> count_o == $past(reload_q));

  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $past(count_o) != '0) |-> count_o == $past(count_o) - CNT_W'(1));

  a_r4_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $past(count_o) == '0) |-> count_o == $past(reload_q));

  a_r5_toggle_on_uflow: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> ((sclk_o != $past(sclk_o)) == $past(uflow_o)));

  a_r6_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!uflow_o && !sclk_o && !tick_o));

  a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !$past(run_q)) |-> $stable(count_o));

  a_r9_tick_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (uflow_o && !sclk_o));
endmodule

bind baud_reload_gen baud_reload_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run_q    (run_q),
  .reload_q (reload_q),
  .count_o  (count_o),
  .uflow_o  (uflow_o),
  .sclk_o   (sclk_o),
  .tick_o   (tick_o)
);

// File: tb/sim_baud_reload_gen.sv
`timescale 1ns/1ps
module sim_baud_reload_gen;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count_o;
  logic         uflow_o, sclk_o, tick_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  baud_reload_gen #(.CNT_W(W), .DIV_SLOW(16), .DIV_FAST(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .count_o(count_o), .uflow_o(uflow_o), .sclk_o(sclk_o), .tick_o(tick_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: run flag, count, reload, speed, serial level, rising-edge tally
  int m_run = 0, m_fast = 0, m_cnt = 0, m_rel = 0, m_sclk = 0, m_rises = 0;

  always @(posedge clk) begin : model
    int uf, nrun, nfast, n;
    if (!rst_n) begin
      m_run = 0; m_fast = 0; m_cnt = 0; m_rel = 0; m_sclk = 0; m_rises = 0;
    end else begin
      uf = (m_run != 0 && m_cnt == 0);
      n = (m_fast != 0) ? 8 : 16;
      nrun = m_run; nfast = m_fast;
      if (wr_en && wr_sel) begin nrun = wr_data[0]; nfast = wr_data[1]; end
      if (m_run == 0 && nrun != 0) m_cnt = m_rel;
      else if (m_run != 0 && nrun != 0) m_cnt = uf ? m_rel : (m_cnt - 1);
      if (nrun == 0) begin
        m_sclk = 0; m_rises = 0;
      end else if (uf) begin
        if (m_sclk == 0) m_rises = (m_rises >= n - 1) ? 0 : m_rises + 1;
        m_sclk = 1 - m_sclk;
      end
      if (wr_en && !wr_sel) m_rel = int'(wr_data);
      m_run = nrun; m_fast = nfast;
    end
  end

  always @(negedge clk) begin : compare
    int euf, etk, n;
    if (rst_n && !done) begin
      n = (m_fast != 0) ? 8 : 16;
      euf = (m_run != 0 && m_cnt == 0) ? 1 : 0;
      etk = (euf != 0 && m_sclk == 0 && m_rises >= n - 1) ? 1 : 0;
      check(int'(count_o) == m_cnt, "R3 count per-cycle", int'(count_o), m_cnt);
      check(int'(uflow_o) == euf, "R4 uflow per-cycle", int'(uflow_o), euf);
      check(int'(sclk_o) == m_sclk, "R5 sclk per-cycle", int'(sclk_o), m_sclk);
      check(int'(tick_o) == etk, "R9 tick per-cycle", int'(tick_o), etk);
    end
  end

  task automatic wr(input bit sel, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_for_uflow(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!uflow_o && k < 1000);
  endtask

  task automatic wait_for_tick(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!tick_o && k < 1000);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin : watchdog
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin : main
    int k, c0, ex;
    repeat (3) @(negedge clk);
    check(count_o == '0, "R1 reset count", int'(count_o), 0);
    check(!uflow_o && !sclk_o && !tick_o, "R1 reset outputs low",
          int'({uflow_o, sclk_o, tick_o}), 0);
    rst_n = 1'b1;

    wr(1'b0, 5);
    wr(1'b1, 3);
    check(count_o == W'(5), "R2 start loads reload", int'(count_o), 5);
    wait_for_uflow(k);
    check(k == 5, "R4 first underflow delay", k, 5);
    check(sclk_o == 1'b0, "R5 sclk low before first underflow", int'(sclk_o), 0);
    @(negedge clk);
    check(sclk_o == 1'b1, "R5 sclk toggles after underflow", int'(sclk_o), 1);
    check(count_o == W'(5), "R4 reload after zero", int'(count_o), 5);
    wait_for_uflow(k);
    check(k + 1 == 6, "R4 underflow period", k + 1, 6);

    wr(1'b0, 2);
    check(count_o != W'(2) || k == 0, "R7 no early pickup", int'(count_o), 4);
    wait_for_uflow(k);
    check(k == 4, "R7 old countdown completes", k, 4);
    @(negedge clk);
    check(count_o == W'(2), "R7 new reload at next underflow", int'(count_o), 2);

    @(negedge clk);
    c0 = int'(count_o);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = W'(3);
    @(negedge clk);
    wr_en = 1'b0;
    ex = (c0 == 0) ? 2 : c0 - 1;
    check(int'(count_o) == ex, "R8 rewrite while running no reload", int'(count_o), ex);

    wr(1'b1, 0);
    c0 = int'(count_o);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(int'(count_o) == c0, "R6 count holds", int'(count_o), c0);
      check(!uflow_o && !sclk_o && !tick_o, "R6 outputs quiet",
            int'({uflow_o, sclk_o, tick_o}), 0);
    end

    wr(1'b1, 3);
    wait_for_tick(k);
    check(k == 44, "R9 divide-by-8 first tick", k, 44);
    wr(1'b1, 0);
    wr(1'b1, 1);
    wait_for_tick(k);
    check(k == 92, "R9 divide-by-16 first tick", k, 92);
    wait_for_tick(k);
    check(k == 96, "R9 divide-by-16 tick spacing", k, 96);

    wr(1'b1, 0);
    wr(1'b0, 0);
    wr(1'b1, 1);
    check(count_o == '0 && uflow_o, "R4 zero reload underflows at once",
          int'(uflow_o), 1);
    @(negedge clk);
    check(uflow_o == 1'b1, "R4 zero reload underflows every cycle", int'(uflow_o), 1);
    check(sclk_o == 1'b1, "R5 zero reload toggles each cycle", int'(sclk_o), 1);

    repeat (200) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule